// File: doc/BRIEF.md
# Fetch-Decode-Execute Sequencer with Trap Entry and Privilege Modes

This block is the control unit of a small processor. It steps each instruction through three phases: fetch (the word at the program counter is read from a synchronous memory port), decode (the returned word is captured in the instruction register and classified), and execute (the program counter, the privilege mode and the side effects are updated). It repeats this until a halt instruction sets the halt flag. The arithmetic datapath and the memory itself are outside the block. The memory is modelled as a single read port that returns data one cycle after the request.

Protection is built into the sequencing. A mode bit separates supervisor (0) from user (1). A trap instruction enters supervisor mode, records a return address, fetches its destination from a table of vectors held in memory, and branches there, all within one instruction. A privileged opcode met in user mode is not executed. It raises a fault that enters supervisor mode at a fixed fault entry. An interrupt request is latched into a pending flag. The flag is examined at the end of each ordinary instruction. When it is taken, the next program counter is saved, control moves to a fixed interrupt entry in supervisor mode, and the flag is cleared. A privileged return instruction restores the saved address and drops back to user mode.

Top module: `fx_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, pc_o equals START_ADDR, halted_o is 0, mode_o is 0 (supervisor), and the first fetch reads address START_ADDR.
- R2: An ordinary instruction takes exactly 3 cycles: fetch, decode, execute. retire_o is high in the execute cycle. Opcode 6 (halt, privileged) sets halted_o, advances pc_o by one, and stops all further memory reads until reset.
- R3: An instruction word holds the opcode in bits [15:12] and a 12-bit immediate in bits [11:0]. Opcode 0 and every opcode not listed in these requirements advance pc_o by one. Opcode 2 (jump) loads pc_o with the immediate.
- R4: Opcode 5 (output, privileged) in supervisor mode pulses io_we_o high for one cycle, with io_data_o equal to immediate bits [7:0]. This happens in the cycle after execute, the same cycle in which pc_o shows the advanced value.
- R5: A one-cycle pulse on irq_i sets a pending flag. At the end of the next ordinary instruction that does not fault, saved_pc_o takes the address that would have come next, pc_o takes IRQ_VEC, mode_o becomes 0, and the flag clears, so the interrupt is taken only once.
- R6: Opcode 3 (trap) in either mode sets mode_o to 0, sets saved_pc_o to its own address plus one, reads the memory word at TRAP_BASE plus immediate bits [3:0], and loads pc_o from that word. The trap takes 4 cycles.
- R7: No instruction except trap lowers the mode to supervisor. mode_o falls only on a trap, a fault or an interrupt entry. Opcode 7 (privileged) sets mode_o to 1 (user).
- R8: The privileged opcodes 4, 5, 6 and 7, issued in user mode, have none of their effects: no io_we_o pulse, no halt, no return and no mode change to user.
- R9: A privileged opcode in user mode pulses fault_o for one cycle, sets saved_pc_o to the faulting instruction's own address, sets pc_o to FAULT_VEC, and sets mode_o to 0.
- R10: Opcode 4 (return, privileged) loads pc_o from saved_pc_o and sets mode_o to 1.
- R11: A pending interrupt is not taken at the end of a trap, a fault or a halt. It stays pending and is taken after the next ordinary instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Read data, valid the cycle after the request |
| irq_i | input | 1 | Interrupt request pulse |
| io_we_o | output | 1 | Output-port write strobe |
| io_data_o | output | IOW | Output-port data |
| pc_o | output | AW | Program counter |
| mode_o | output | 1 | Privilege mode, 0 supervisor, 1 user |
| halted_o | output | 1 | Halt flag |
| fault_o | output | 1 | Protection fault pulse |
| saved_pc_o | output | AW | Saved return address |
| retire_o | output | 1 | Instruction completes this cycle |

## Verification
The bench uses the default parameters: a 16-bit word, a 12-bit address, an 8-bit output port, a start address of 0, entries at 0x040 for interrupts and 0x050 for faults, and a vector table at 0x0F0. With these values, every entry point and the whole trap table fit in the first 256 words of the memory model. A short program can therefore reach user mode, fault, trap, take an interrupt and return. Randomly chosen opcodes are run in user mode to cover the privileged/ordinary split. Random output values are run in supervisor mode to cover the data path to the port.

// File: rtl/fx_seq_pkg.sv
package fx_seq_pkg;

    localparam int unsigned OPW = 4;

    localparam logic [OPW-1:0] OPC_NOP  = 4'h0;
    localparam logic [OPW-1:0] OPC_JUMP = 4'h2;
    localparam logic [OPW-1:0] OPC_TRAP = 4'h3;
    localparam logic [OPW-1:0] OPC_RET  = 4'h4;
    localparam logic [OPW-1:0] OPC_OUT  = 4'h5;
    localparam logic [OPW-1:0] OPC_HALT = 4'h6;
    localparam logic [OPW-1:0] OPC_USER = 4'h7;

    localparam logic MODE_SUP = 1'b0;
    localparam logic MODE_USR = 1'b1;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_VECTOR,
        ST_STOP
    } phase_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_JUMP,
        K_TRAP,
        K_RET,
        K_OUT,
        K_HALT,
        K_USER
    } kind_e;

endpackage

// File: rtl/fx_seq_decode.sv
module fx_seq_decode
    import fx_seq_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned AW  = 12,
    parameter int unsigned IOW = 8
) (
    input  logic [DW-1:0]  ir_i,
    output kind_e          kind_o,
    output logic           priv_o,
    output logic [AW-1:0]  target_o,
    output logic [IOW-1:0] io_val_o,
    output logic [3:0]     tidx_o
);
    localparam int unsigned IMMW = DW - OPW;

    logic [OPW-1:0]  opc;
    logic [IMMW-1:0] imm;

    assign opc      = ir_i[DW-1 -: OPW];
    assign imm      = ir_i[IMMW-1:0];
    assign target_o = imm[AW-1:0];
    assign io_val_o = imm[IOW-1:0];
    assign tidx_o   = imm[3:0];

    always_comb begin
        kind_o = K_NOP;
        priv_o = 1'b0;
        case (opc)
            OPC_JUMP: kind_o = K_JUMP;
            OPC_TRAP: kind_o = K_TRAP;
            OPC_RET:  begin kind_o = K_RET;  priv_o = 1'b1; end
            OPC_OUT:  begin kind_o = K_OUT;  priv_o = 1'b1; end
            OPC_HALT: begin kind_o = K_HALT; priv_o = 1'b1; end
            OPC_USER: begin kind_o = K_USER; priv_o = 1'b1; end
            default:  kind_o = K_NOP;
        endcase
    end
endmodule

// File: rtl/fx_seq_irqflag.sv
module fx_seq_irqflag (
    input  logic clk,
    input  logic rst_n,
    input  logic raise_i,
    input  logic take_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    // a new request in the same cycle as a take keeps the flag set
    always_comb begin
        pend_d = (pend_q & ~take_i) | raise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
    import fx_seq_pkg::*;
#(
    parameter int unsigned     DW  = 16,
    parameter int unsigned     AW  = 12,
    parameter int unsigned     IOW = 8,
    parameter logic [AW-1:0]   START_ADDR = '0,
    parameter logic [AW-1:0]   IRQ_VEC    = AW'('h040),
    parameter logic [AW-1:0]   FAULT_VEC  = AW'('h050),
    parameter logic [AW-1:0]   TRAP_BASE  = AW'('h0F0)
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic           mem_rd_o,
    output logic [AW-1:0]  mem_addr_o,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           irq_i,
    output logic           io_we_o,
    output logic [IOW-1:0] io_data_o,
    output logic [AW-1:0]  pc_o,
    output logic           mode_o,
    output logic           halted_o,
    output logic           fault_o,
    output logic [AW-1:0]  saved_pc_o,
    output logic           retire_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    typedef struct packed {
        phase_e         st;
        logic [AW-1:0]  pc;
        logic [DW-1:0]  ir;
        logic           mode;
        logic           halt;
        logic [AW-1:0]  epc;
        logic           io_we;
        logic [IOW-1:0] io_data;
        logic           fault;
    } regs_t;

    regs_t q, d;

    kind_e          kind;
    logic           priv;
    logic [AW-1:0]  jtgt;
    logic [IOW-1:0] io_val;
    logic [3:0]     tidx;
    logic           pend;
    logic           irq_take;
    logic           exec_trap;
    logic           exec_fault;
    logic [AW-1:0]  pc_inc;
    logic [AW-1:0]  next_pc;

    fx_seq_decode #(.DW(DW), .AW(AW), .IOW(IOW)) u_dec (
        .ir_i     (q.ir),
        .kind_o   (kind),
        .priv_o   (priv),
        .target_o (jtgt),
        .io_val_o (io_val),
        .tidx_o   (tidx)
    );

    fx_seq_irqflag u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise_i (irq_i),
        .take_i  (irq_take),
        .pend_o  (pend)
    );

    assign pc_inc = q.pc + ONE;

    always_comb begin
        d          = q;
        d.io_we    = 1'b0;
        d.fault    = 1'b0;
        mem_rd_o   = 1'b0;
        mem_addr_o = q.pc;
        retire_o   = 1'b0;
        irq_take   = 1'b0;
        exec_trap  = 1'b0;
        exec_fault = 1'b0;
        next_pc    = pc_inc;

        case (q.st)
            ST_FETCH: begin
                mem_rd_o = 1'b1;
                d.st     = ST_DECODE;
            end
            ST_DECODE: begin
                d.ir = mem_rdata_i;
                d.st = ST_EXEC;
            end
            ST_EXEC: begin
                if (priv && q.mode == MODE_USR) begin
                    // blocked: vector to the fault entry, remember the culprit
                    exec_fault = 1'b1;
                    retire_o   = 1'b1;
                    d.fault    = 1'b1;
                    d.epc      = q.pc;
                    d.pc       = FAULT_VEC;
                    d.mode     = MODE_SUP;
                    d.st       = ST_FETCH;
                end else if (kind == K_TRAP) begin
                    // table lookup now, branch when the word returns
                    exec_trap  = 1'b1;
                    mem_rd_o   = 1'b1;
                    mem_addr_o = TRAP_BASE + {{(AW-4){1'b0}}, tidx};
                    d.epc      = pc_inc;
                    d.mode     = MODE_SUP;
                    d.st       = ST_VECTOR;
                end else if (kind == K_HALT) begin
                    retire_o = 1'b1;
                    d.halt   = 1'b1;
                    d.pc     = pc_inc;
                    d.st     = ST_STOP;
                end else begin
                    retire_o = 1'b1;
                    case (kind)
                        K_JUMP: next_pc = jtgt;
                        K_RET: begin
                            next_pc = q.epc;
                            d.mode  = MODE_USR;
                        end
                        K_OUT: begin
                            d.io_we   = 1'b1;
                            d.io_data = io_val;
                        end
                        K_USER: d.mode = MODE_USR;
                        default: next_pc = pc_inc;
                    endcase
                    if (pend) begin
                        irq_take = 1'b1;
                        d.epc    = next_pc;
                        d.pc     = IRQ_VEC;
                        d.mode   = MODE_SUP;
                    end else begin
                        d.pc = next_pc;
                    end
                    d.st = ST_FETCH;
                end
            end
            ST_VECTOR: begin
                retire_o = 1'b1;
                d.pc     = mem_rdata_i[AW-1:0];
                d.st     = ST_FETCH;
            end
            ST_STOP: begin
                d.st = ST_STOP;
            end
            default: d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_FETCH;
            q.pc      <= START_ADDR;
            q.ir      <= '0;
            q.mode    <= MODE_SUP;
            q.halt    <= 1'b0;
            q.epc     <= '0;
            q.io_we   <= 1'b0;
            q.io_data <= '0;
            q.fault   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pc_o       = q.pc;
    assign mode_o     = q.mode;
    assign halted_o   = q.halt;
    assign fault_o    = q.fault;
    assign saved_pc_o = q.epc;
    assign io_we_o    = q.io_we;
    assign io_data_o  = q.io_data;
endmodule

// File: rtl/fx_sequencer_chk.sv
module fx_sequencer_chk #(
    parameter int unsigned   AW        = 12,
    parameter logic [AW-1:0] IRQ_VEC   = AW'('h040),
    parameter logic [AW-1:0] FAULT_VEC = AW'('h050)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_o,
    input logic          halted_o,
    input logic          mem_rd_o,
    input logic          io_we_o,
    input logic          fault_o,
    input logic          retire_o,
    input logic [AW-1:0] pc_o,
    input logic          exec_trap,
    input logic          exec_fault,
    input logic          irq_take
);
    p_mode_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_o) |-> $past(exec_trap || exec_fault || irq_take));

    p_user_no_io_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_we_o |-> $past(mode_o) == 1'b0);

    p_halt_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (halted_o && !mem_rd_o));

    p_fault_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (pc_o == FAULT_VEC && mode_o == 1'b0));

    p_irq_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> (pc_o == IRQ_VEC && mode_o == 1'b0));

    p_trap_lookup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_trap |-> mem_rd_o ##1 retire_o);

    p_no_irq_on_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_trap || exec_fault) |-> !irq_take);
endmodule

bind fx_sequencer fx_sequencer_chk #(
    .AW(AW), .IRQ_VEC(IRQ_VEC), .FAULT_VEC(FAULT_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_o     (mode_o),
    .halted_o   (halted_o),
    .mem_rd_o   (mem_rd_o),
    .io_we_o    (io_we_o),
    .fault_o    (fault_o),
    .retire_o   (retire_o),
    .pc_o       (pc_o),
    .exec_trap  (exec_trap),
    .exec_fault (exec_fault),
    .irq_take   (irq_take)
);

// File: tb/fx_sequencer_bench.sv
module fx_sequencer_bench;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int IOW = 8;
    localparam int IRQ_E = 'h040;
    localparam int FLT_E = 'h050;
    localparam int TBASE = 'h0F0;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mem_rd_o;
    logic [AW-1:0]  mem_addr_o;
    logic [DW-1:0]  mem_rdata_i = '0;
    logic           irq_i = 1'b0;
    logic           io_we_o;
    logic [IOW-1:0] io_data_o;
    logic [AW-1:0]  pc_o;
    logic           mode_o;
    logic           halted_o;
    logic           fault_o;
    logic [AW-1:0]  saved_pc_o;
    logic           retire_o;

    logic [DW-1:0] mem [256];
    int total = 0;
    int bad = 0;
    int ncyc;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[7:0]];

    fx_sequencer u_fx_sequencer (
        .clk(clk), .rst_n(rst_n), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_rdata_i(mem_rdata_i), .irq_i(irq_i), .io_we_o(io_we_o),
        .io_data_o(io_data_o), .pc_o(pc_o), .mode_o(mode_o), .halted_o(halted_o),
        .fault_o(fault_o), .saved_pc_o(saved_pc_o), .retire_o(retire_o)
    );

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [11:0] imm);
        return {op, imm};
    endfunction

    function automatic logic is_priv(input logic [3:0] op);
        return (op >= 4'd4) && (op <= 4'd7);
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // run to one cycle after the next retire; ncyc = cycles taken
    task automatic step();
        ncyc = 0;
        do begin
            @(negedge clk);
            irq_i = 1'b0;
            ncyc++;
        end while (!retire_o);
        @(negedge clk);
        ncyc++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));

        // program A: ordinary flow, user mode, fault, trap, halt
        clear_mem();
        mem[0]    = enc(4'h0, 12'h000);
        mem[1]    = enc(4'h5, 12'h05A);
        mem[2]    = enc(4'h2, 12'h010);
        mem['h10] = enc(4'h7, 12'h000);
        mem['h11] = enc(4'h5, 12'h033);
        mem['h50] = enc(4'h2, 12'h060);
        mem['h60] = enc(4'h3, 12'h002);
        mem[TBASE+2] = 16'h0070;
        mem['h70] = enc(4'h6, 12'h000);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset pc", pc_o, 0);
        chk("R1 reset halted", halted_o, 0);
        chk("R1 reset mode", mode_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first decode after fetch at start", pc_o, 0);
        // rewind: restart cleanly for cycle counting
        do_reset();
        step();
        chk("R2 ordinary cycles", ncyc, 3);
        chk("R3 nop pc", pc_o, 1);
        step();
        chk("R4 io strobe", io_we_o, 1);
        chk("R4 io data", io_data_o, 'h5A);
        chk("R4 pc", pc_o, 2);
        @(negedge clk);
        chk("R4 strobe one cycle", io_we_o, 0);
        step();
        chk("R3 jump pc", pc_o, 'h10);
        step();
        chk("R7 user mode set", mode_o, 1);
        step();
        chk("R8 no io in user", io_we_o, 0);
        chk("R9 fault pulse", fault_o, 1);
        chk("R9 fault pc", pc_o, FLT_E);
        chk("R9 fault mode", mode_o, 0);
        chk("R9 fault saved", saved_pc_o, 'h11);
        step();
        chk("R3 jump to trap site", pc_o, 'h60);
        step();
        chk("R6 trap cycles", ncyc, 4);
        chk("R6 trap pc", pc_o, 'h70);
        chk("R6 trap mode", mode_o, 0);
        chk("R6 trap saved", saved_pc_o, 'h61);
        step();
        chk("R2 halted", halted_o, 1);
        chk("R2 halt pc", pc_o, 'h71);
        begin
            int reads = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (mem_rd_o) reads++;
            end
            chk("R2 no fetch after halt", reads, 0);
            chk("R2 still halted", halted_o, 1);
        end

        // program B: interrupt entry and return
        clear_mem();
        mem[0] = enc(4'h7, 12'h000);
        mem[1] = enc(4'h0, 12'h000);
        mem[2] = enc(4'h0, 12'h000);
        mem[3] = enc(4'h0, 12'h000);
        mem[IRQ_E] = enc(4'h4, 12'h000);
        do_reset();
        step();
        irq_i = 1'b1;
        step();
        chk("R5 irq pc", pc_o, IRQ_E);
        chk("R5 irq saved", saved_pc_o, 2);
        chk("R5 irq mode", mode_o, 0);
        step();
        chk("R10 return pc", pc_o, 2);
        chk("R10 return mode", mode_o, 1);
        step();
        chk("R5 flag cleared", pc_o, 3);

        // program C: interrupt held over a trap
        clear_mem();
        mem[0] = enc(4'h7, 12'h000);
        mem[1] = enc(4'h3, 12'h005);
        mem[TBASE+5] = 16'h0020;
        mem['h20] = enc(4'h0, 12'h000);
        do_reset();
        step();
        irq_i = 1'b1;
        step();
        chk("R11 trap not preempted", pc_o, 'h20);
        chk("R11 trap saved", saved_pc_o, 2);
        step();
        chk("R11 irq after next", pc_o, IRQ_E);
        chk("R11 saved after next", saved_pc_o, 'h21);

        // random opcodes in user mode
        for (int k = 0; k < 40; k++) begin
            int r;
            logic [3:0] op;
            logic [11:0] imm;
            r = int'($urandom % 14);
            op = (r < 2) ? 4'(r) : 4'(r + 2);
            imm = 12'($urandom);
            clear_mem();
            mem[0] = enc(4'h7, 12'h000);
            mem[1] = enc(op, imm);
            do_reset();
            step();
            step();
            if (is_priv(op)) begin
                chk("R8 priv blocked pc", pc_o, FLT_E);
                chk("R9 priv fault", fault_o, 1);
                chk("R8 priv mode", mode_o, 0);
                chk("R8 no halt", halted_o, 0);
            end else begin
                chk("R3 plain pc", pc_o, 2);
                chk("R7 plain mode", mode_o, 1);
                chk("R9 no fault", fault_o, 0);
            end
            chk("R8 no io", io_we_o, 0);
        end

        // random output values in supervisor mode
        clear_mem();
        begin
            logic [7:0] vals [8];
            for (int i = 0; i < 8; i++) begin
                vals[i] = 8'($urandom);
                mem[i] = enc(4'h5, {4'($urandom), vals[i]});
            end
            do_reset();
            for (int i = 0; i < 8; i++) begin
                step();
                chk("R4 rand strobe", io_we_o, 1);
                chk("R4 rand data", io_data_o, vals[i]);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule